// File: doc/BRIEF.md
# Pipeline RAW Hazard Interlock

This unit decides, every cycle, whether the front of a five-stage in-order integer pipeline (fetch, decode/read, execute, memory, writeback) has to freeze. It takes the two source register numbers of the instruction sitting in the decode latch. It compares each of them against the destination register numbers of the instructions in the execute, memory and writeback latches, which makes six comparators in all. When a real read-after-write dependence is found that the pipeline cannot resolve, the unit does three things. It holds the program counter, it holds the decode latch, and it tells the execute latch to load a no-op bubble instead of the decoded control word.

False matches are filtered out before any decision is taken. A match only counts when three things hold. The older instruction is valid and actually writes a register. The younger instruction actually reads that source port. The register number is not zero, since register 0 is wired to zero.

A mode input selects the stall policy. In full-interlock mode, a consumer waits until its producer has reached writeback. The register file writes before it reads within a cycle, so a writeback producer never stalls. In bypass mode, forwarding supplies every result except a load that is still in execute. Only that load-to-next-instruction case stalls, and it stalls for exactly one cycle. The register number width is a parameter: 5 bits by default, 6 bits supported.

Top module: `hazard_interlock`

## Requirements
- R1: With bypass_mode_i = 0, a stall is raised when either used source of a valid decode instruction equals the destination of a valid, register-writing instruction in the execute latch or in the memory latch.
- R2: A later-stage instruction whose valid flag or register-write flag is 0 (for example a store) never causes a stall.
- R3: A source port whose use flag is 0 (second port of an immediate op, both ports of a jump) never causes a stall.
- R4: A source register number of 0 never causes a stall, even when a producer writes register 0.
- R5: While stalled, pc_we_o = 0 and if_id_we_o = 0. Otherwise both are 1.
- R6: ex_bubble_o = 1 exactly in the cycles in which a stall is raised.
- R7: With bypass_mode_i = 1, a stall is raised only when the matching producer is in the execute latch with ex_is_load_i = 1. Matches against a non-load in execute, or against anything in memory or writeback, do not stall. On a correctly advancing pipeline, such a stall lasts exactly one cycle.
- R8: With bypass_mode_i = 0, a match against the writeback latch alone never stalls.
- R9: When id_valid_i = 0 no stall is raised, whatever the later stages hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the bound property checker |
| rst_ni | input | 1 | Active-low asynchronous reset, used by the bound property checker |
| bypass_mode_i | input | 1 | 0 = full interlock, 1 = load-use-only interlock |
| id_valid_i | input | 1 | Decode latch holds a real instruction |
| id_rs1_i | input | REG_W | Decode source register 1 |
| id_rs1_used_i | input | 1 | Source 1 is read |
| id_rs2_i | input | REG_W | Decode source register 2 |
| id_rs2_used_i | input | 1 | Source 2 is read |
| ex_valid_i | input | 1 | Execute latch holds a real instruction |
| ex_rd_i | input | REG_W | Execute destination register |
| ex_reg_write_i | input | 1 | Execute instruction writes a register |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| mem_valid_i | input | 1 | Memory latch holds a real instruction |
| mem_rd_i | input | REG_W | Memory destination register |
| mem_reg_write_i | input | 1 | Memory instruction writes a register |
| wb_valid_i | input | 1 | Writeback latch holds a real instruction |
| wb_rd_i | input | REG_W | Writeback destination register |
| wb_reg_write_i | input | 1 | Writeback instruction writes a register |
| pc_we_o | output | 1 | Program counter update enable |
| if_id_we_o | output | 1 | Decode latch update enable |
| ex_bubble_o | output | 1 | Load a no-op into the execute latch |

## Verification
The temporal properties assume that the surrounding pipeline honours the unit's decisions. In the cycle after a bubble is requested, the execute latch must hold no valid instruction, and the decode contents must stay put while stalled. The one-cycle load-use property in bypass mode rests on that assumption and on the mode staying stable. The bench meets this by driving every input from its own pipeline model, which shifts the latches and inserts bubbles exactly as the requirements say. Each directed vector is followed by an all-idle cycle, so arbitrary snapshots never look like an illegal pipeline progression.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned N_PROD = 3;  // producer latches: execute, memory, writeback
  localparam int unsigned N_SRC  = 2;  // decode read ports
  localparam int unsigned STG_EX  = 0;
  localparam int unsigned STG_MEM = 1;
  localparam int unsigned STG_WB  = 2;
endpackage

// File: rtl/hzd_cmp.sv
module hzd_cmp #(
  parameter int unsigned REG_W = 5
) (
  input  logic             src_ok_i,
  input  logic             src_used_i,
  input  logic [REG_W-1:0] src_reg_i,
  input  logic             dst_wr_i,
  input  logic [REG_W-1:0] dst_reg_i,
  output logic             hit_o
);
  logic nonzero;
  logic same;

  assign nonzero = |src_reg_i;
  assign same    = (src_reg_i == dst_reg_i);
  assign hit_o   = src_ok_i & src_used_i & dst_wr_i & nonzero & same;
endmodule

// File: rtl/hzd_match_array.sv
module hzd_match_array
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic                          id_valid_i,
  input  logic [N_SRC-1:0][REG_W-1:0]   src_reg_i,
  input  logic [N_SRC-1:0]              src_used_i,
  input  logic [N_PROD-1:0][REG_W-1:0]  dst_reg_i,
  input  logic [N_PROD-1:0]             dst_wr_i,
  output logic [N_PROD-1:0][N_SRC-1:0]  hit_o
);
  for (genvar s = 0; s < N_PROD; s++) begin : g_prod
    for (genvar p = 0; p < N_SRC; p++) begin : g_src
      hzd_cmp #(.REG_W(REG_W)) u_cmp (
        .src_ok_i  (id_valid_i),
        .src_used_i(src_used_i[p]),
        .src_reg_i (src_reg_i[p]),
        .dst_wr_i  (dst_wr_i[s]),
        .dst_reg_i (dst_reg_i[s]),
        .hit_o     (hit_o[s][p])
      );
    end
  end
endmodule

// File: rtl/hzd_policy.sv
module hzd_policy
  import hzd_pkg::*;
#(
  parameter bit RF_WRITE_FIRST = 1'b1
) (
  input  logic [N_PROD-1:0][N_SRC-1:0] hit_i,
  input  logic                         bypass_i,
  input  logic                         ex_is_load_i,
  output logic                         stall_o
);
  logic ex_any, mem_any, wb_any;
  logic full_stall, byp_stall;

  assign ex_any  = |hit_i[STG_EX];
  assign mem_any = |hit_i[STG_MEM];
  assign wb_any  = |hit_i[STG_WB];

  // writeback matters only when the register file reads before it writes
  assign full_stall = ex_any | mem_any | (wb_any & ~RF_WRITE_FIRST);
  assign byp_stall  = ex_any & ex_is_load_i;

  always_comb begin
    if (bypass_i) stall_o = byp_stall;
    else          stall_o = full_stall;
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl (
  input  logic stall_i,
  output logic pc_we_o,
  output logic if_id_we_o,
  output logic bubble_o
);
  assign pc_we_o    = ~stall_i;
  assign if_id_we_o = ~stall_i;
  assign bubble_o   = stall_i;
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W          = 5,
  parameter bit          RF_WRITE_FIRST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_mode_i,
  input  logic             id_valid_i,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic             id_rs1_used_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_rs2_used_i,
  input  logic             ex_valid_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_reg_write_i,
  input  logic             ex_is_load_i,
  input  logic             mem_valid_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_reg_write_i,
  input  logic             wb_valid_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_reg_write_i,
  output logic             pc_we_o,
  output logic             if_id_we_o,
  output logic             ex_bubble_o
);
  logic [N_SRC-1:0][REG_W-1:0]  src_reg;
  logic [N_SRC-1:0]             src_used;
  logic [N_PROD-1:0][REG_W-1:0] dst_reg;
  logic [N_PROD-1:0]            dst_wr;
  logic [N_PROD-1:0][N_SRC-1:0] hit;
  logic                         stall;

  assign src_reg[0]  = id_rs1_i;
  assign src_reg[1]  = id_rs2_i;
  assign src_used[0] = id_rs1_used_i;
  assign src_used[1] = id_rs2_used_i;

  assign dst_reg[STG_EX]  = ex_rd_i;
  assign dst_reg[STG_MEM] = mem_rd_i;
  assign dst_reg[STG_WB]  = wb_rd_i;
  assign dst_wr[STG_EX]   = ex_valid_i  & ex_reg_write_i;
  assign dst_wr[STG_MEM]  = mem_valid_i & mem_reg_write_i;
  assign dst_wr[STG_WB]   = wb_valid_i  & wb_reg_write_i;

  hzd_match_array #(.REG_W(REG_W)) u_match (
    .id_valid_i(id_valid_i),
    .src_reg_i (src_reg),
    .src_used_i(src_used),
    .dst_reg_i (dst_reg),
    .dst_wr_i  (dst_wr),
    .hit_o     (hit)
  );

  hzd_policy #(.RF_WRITE_FIRST(RF_WRITE_FIRST)) u_policy (
    .hit_i       (hit),
    .bypass_i    (bypass_mode_i),
    .ex_is_load_i(ex_is_load_i),
    .stall_o     (stall)
  );

  hzd_ctrl u_ctrl (
    .stall_i   (stall),
    .pc_we_o   (pc_we_o),
    .if_id_we_o(if_id_we_o),
    .bubble_o  (ex_bubble_o)
  );
endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bypass_mode_i,
  input logic             id_valid_i,
  input logic [REG_W-1:0] id_rs1_i,
  input logic             id_rs1_used_i,
  input logic [REG_W-1:0] id_rs2_i,
  input logic             id_rs2_used_i,
  input logic             ex_valid_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_reg_write_i,
  input logic             ex_is_load_i,
  input logic             mem_valid_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_reg_write_i,
  input logic             wb_valid_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             wb_reg_write_i,
  input logic             pc_we_o,
  input logic             if_id_we_o,
  input logic             ex_bubble_o
);
  p_front_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o == if_id_we_o);

  p_bubble_on_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_bubble_o != pc_we_o);

  p_idle_decode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> pc_we_o);

  p_zero_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((id_rs1_i == '0 || !id_rs1_used_i) && (id_rs2_i == '0 || !id_rs2_used_i)) |-> pc_we_o);

  p_no_writer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ex_valid_i && ex_reg_write_i) && !(mem_valid_i && mem_reg_write_i)) |-> pc_we_o);

  p_no_reader_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_rs1_used_i && !id_rs2_used_i) |-> !ex_bubble_o);

  p_wb_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_mode_i && !ex_valid_i && !mem_valid_i) |-> pc_we_o);

  p_bypass_load_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_mode_i && !ex_is_load_i) |-> pc_we_o);

  p_bypass_single_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_mode_i && ex_bubble_o) |=> (!ex_bubble_o || !$stable(bypass_mode_i)));

  // environment: a requested bubble must appear in the execute latch (R6)
  p_env_bubble_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_bubble_o |=> !ex_valid_i);
endmodule

bind hazard_interlock hazard_interlock_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hazard_interlock_tb.sv
module hazard_interlock_tb;
  localparam int unsigned RW = 5;

  typedef struct packed {
    logic          v;
    logic [RW-1:0] rd;
    logic          wr;
    logic          ld;
    logic [RW-1:0] rs1;
    logic          u1;
    logic [RW-1:0] rs2;
    logic          u2;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          byp;
  ins_t          s_id, s_ex, s_mem, s_wb;
  logic          pc_we, ifid_we, bubble;

  int compared = 0;
  int mismatched = 0;

  hazard_interlock #(.REG_W(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bypass_mode_i(byp),
    .id_valid_i(s_id.v), .id_rs1_i(s_id.rs1), .id_rs1_used_i(s_id.u1),
    .id_rs2_i(s_id.rs2), .id_rs2_used_i(s_id.u2),
    .ex_valid_i(s_ex.v), .ex_rd_i(s_ex.rd), .ex_reg_write_i(s_ex.wr), .ex_is_load_i(s_ex.ld),
    .mem_valid_i(s_mem.v), .mem_rd_i(s_mem.rd), .mem_reg_write_i(s_mem.wr),
    .wb_valid_i(s_wb.v), .wb_rd_i(s_wb.rd), .wb_reg_write_i(s_wb.wr),
    .pc_we_o(pc_we), .if_id_we_o(ifid_we), .ex_bubble_o(bubble)
  );

  function automatic ins_t mk(bit v, int rd, bit wr, bit ld, int rs1, bit u1, int rs2, bit u2);
    ins_t t;
    t.v = v; t.rd = RW'(rd); t.wr = wr; t.ld = ld;
    t.rs1 = RW'(rs1); t.u1 = u1; t.rs2 = RW'(rs2); t.u2 = u2;
    return t;
  endfunction

  // does consumer c read something producer p writes
  function automatic bit reads_from(ins_t c, ins_t p);
    if (!c.v || !p.v || !p.wr) return 1'b0;
    if (c.u1 && c.rs1 != 0 && c.rs1 == p.rd) return 1'b1;
    if (c.u2 && c.rs2 != 0 && c.rs2 == p.rd) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit model_stall(bit mode, ins_t d, ins_t e, ins_t m);
    if (mode) return e.ld && reads_from(d, e);
    return reads_from(d, e) || reads_from(d, m);
  endfunction

  task automatic check_out(bit exp_stall, string tag);
    compared++;
    if (pc_we !== !exp_stall) begin
      mismatched++;
      $display("FAIL %s/R5 pc_we_o actual=%b expected=%b", tag, pc_we, !exp_stall);
    end
    compared++;
    if (ifid_we !== !exp_stall) begin
      mismatched++;
      $display("FAIL %s/R5 if_id_we_o actual=%b expected=%b", tag, ifid_we, !exp_stall);
    end
    compared++;
    if (bubble !== exp_stall) begin
      mismatched++;
      $display("FAIL %s/R6 ex_bubble_o actual=%b expected=%b", tag, bubble, exp_stall);
    end
  endtask

  ins_t idle;

  // apply one snapshot, check it, then one idle cycle
  task automatic vec(bit mode, ins_t d, ins_t e, ins_t m, ins_t w, bit exp_stall, string tag);
    @(negedge clk);
    byp = mode; s_id = d; s_ex = e; s_mem = m; s_wb = w;
    #1 check_out(exp_stall, tag);
    @(negedge clk);
    s_id = idle; s_ex = idle; s_mem = idle; s_wb = idle;
  endtask

  function automatic ins_t fetch();
    int k = $urandom % 5;
    int a = $urandom % 4, b = $urandom % 4, c = $urandom % 4;
    bit v = ($urandom % 10) != 0;
    case (k)
      0: return mk(v, a, 1, 0, b, 1, c, 1);  // register ALU
      1: return mk(v, a, 1, 0, b, 1, c, 0);  // immediate ALU
      2: return mk(v, a, 1, 1, b, 1, c, 0);  // load
      3: return mk(v, a, 0, 0, b, 1, c, 1);  // store
      default: return mk(v, a, 0, 0, b, 0, c, 0);  // jump
    endcase
  endfunction

  task automatic run_pipe(bit mode, int cycles);
    int run_len = 0;
    @(negedge clk);
    byp = mode; s_id = idle; s_ex = idle; s_mem = idle; s_wb = idle;
    for (int i = 0; i < cycles; i++) begin
      bit st;
      string tag;
      @(negedge clk);
      #1;
      st = model_stall(mode, s_id, s_ex, s_mem);
      if (st && mode) tag = "R7";
      else if (st) tag = "R1";
      else if (!mode && reads_from(s_id, s_wb)) tag = "R8";
      else if (!s_id.v) tag = "R9";
      else tag = "R2";
      check_out(st, tag);
      run_len = st ? run_len + 1 : 0;
      if (mode && run_len > 1) begin
        mismatched++;
        $display("FAIL R7 load-use stall length actual=%0d expected=1", run_len);
      end
      s_wb = s_mem;
      s_mem = s_ex;
      if (st) s_ex = idle;
      else begin
        s_ex = s_id;
        s_id = fetch();
      end
    end
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle = '0;
    byp = 1'b0; s_id = idle; s_ex = idle; s_mem = idle; s_wb = idle;
    #2 check_out(1'b0, "R9 reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 execute and memory producers, either port
    vec(0, mk(1,9,1,0,3,1,1,1), mk(1,3,1,0,0,0,0,0), idle, idle, 1, "R1 ex rs1");
    vec(0, mk(1,9,1,0,1,1,4,1), idle, mk(1,4,1,1,0,0,0,0), idle, 1, "R1 mem rs2");
    // R2 store or invalid producer
    vec(0, mk(1,9,1,0,3,1,0,0), mk(1,3,0,0,0,0,0,0), idle, idle, 0, "R2 store");
    vec(0, mk(1,9,1,0,3,1,0,0), mk(0,3,1,0,0,0,0,0), mk(1,3,0,0,0,0,0,0), idle, 0, "R2 invalid");
    // R3 unused ports
    vec(0, mk(1,9,1,0,1,1,5,0), mk(1,5,1,0,0,0,0,0), idle, idle, 0, "R3 imm");
    vec(0, mk(1,0,0,0,5,0,5,0), mk(1,5,1,0,0,0,0,0), mk(1,5,1,0,0,0,0,0), idle, 0, "R3 jump");
    // R4 register zero
    vec(0, mk(1,9,1,0,0,1,0,1), mk(1,0,1,0,0,0,0,0), mk(1,0,1,1,0,0,0,0), idle, 0, "R4 zero");
    // R8 writeback producer
    vec(0, mk(1,9,1,0,6,1,6,1), idle, idle, mk(1,6,1,0,0,0,0,0), 0, "R8 wb");
    // R7 bypass policy
    vec(1, mk(1,9,1,0,7,1,0,0), mk(1,7,1,0,0,0,0,0), idle, idle, 0, "R7 alu ex");
    vec(1, mk(1,9,1,0,1,1,7,1), mk(1,7,1,1,0,0,0,0), idle, idle, 1, "R7 load ex");
    vec(1, mk(1,9,1,0,1,1,2,1), idle, mk(1,2,1,1,0,0,0,0), idle, 0, "R7 load mem");
    vec(1, mk(1,9,1,0,8,1,8,1), idle, mk(1,8,1,0,0,0,0,0), mk(1,8,1,0,0,0,0,0), 0, "R7 mem wb");
    // R9 idle decode
    vec(0, mk(0,9,1,0,3,1,3,1), mk(1,3,1,1,0,0,0,0), mk(1,3,1,0,0,0,0,0), idle, 0, "R9 idle");

    run_pipe(0, 3000);
    run_pipe(1, 3000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule